// File: doc/BRIEF.md
# Burst-of-four double-rate SRAM host controller

This block sits between an on-chip requester and an external synchronous SRAM. The SRAM has a shared data bus, a fixed burst of four words, and moves data on both halves of each clock. A requester hands over one burst at a time through a valid/ready handshake. A request carries a direction flag, a burst address, four write words and active-low byte enables for every beat. The controller turns each accepted request into one command cycle on the memory side. For a write, it then drives the four beats over the next two cycles. For a read, it collects the four returning beats at a fixed offset from the command and hands them back as one packed response.

Both clock phases of the memory bus appear at this block's ports as rise and fall lanes of a single-rate clock. The pad layer, which is outside this block, serialises these lanes onto the wires and presents captured read beats to it the same way. The controller spaces commands at least two cycles apart. It adds one more cycle when a write follows a read, so that there is always an undriven half-cycle between the memory driving the bus and the controller driving it.

Top module: `ddrb_host_ctrl`

## Requirements
- R1: `sram_ld_n` is never low in two consecutive cycles.
- R2: A request accepted in cycle a (req_valid and req_ready both high) produces a command in cycle a+1:
  - `sram_ld_n` is 0;
  - `sram_addr` is the request address;
  - `sram_rw_n` is 0 for a write and 1 for a read.
- R3: With req_valid held high, each acceptance follows the previous one by exactly 2 cycles, except a write after a read, which follows by exactly 3 cycles.
- R4: In the cycle after a write command, `sram_d_rise`/`sram_d_fall` carry words 0/1, and in the next cycle words 2/3.
  - Each word occupies `req_wdata[i*DATA_W +: DATA_W]`.
  - The matching byte enables travel on `sram_bw_rise_n`/`sram_bw_fall_n`, taken from `req_bw_n[i*BYTES +: BYTES]`. Bit j covers byte j, and 0 means write.
  - `sram_dq_oe` is high in exactly those two cycles.
- R5: `sram_rw_n` is 1 in every cycle in which `sram_ld_n` is 1, so that no write is signalled without a command.
- R6: `sram_dq_oe` is low in each of the three cycles following a read command.
- R7: For a read command in cycle t, the beats are taken from these lanes:
  - beat 0 from `sram_q_fall` in cycle t+1;
  - beat 1 from `sram_q_rise` and beat 2 from `sram_q_fall` in cycle t+2;
  - beat 3 from `sram_q_rise` in cycle t+3.
  - Beat i is returned in `resp_rdata[i*DATA_W +: DATA_W]`.
- R8: Each read produces one single-cycle `resp_valid` pulse in cycle t+4 after its command (a+5 after acceptance), and no other pulse occurs.
- R9: After reset, `sram_ld_n`=1, `sram_rw_n`=1, `sram_dq_oe`=0, `resp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one memory command slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Burst address |
| req_wdata | input | 4*DATA_W | Four write words, word i at i*DATA_W |
| req_bw_n | input | 4*BYTES | Active-low byte enables, beat i at i*BYTES |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| sram_ld_n | output | 1 | Active-low command strobe |
| sram_rw_n | output | 1 | 1 = read or idle, 0 = write |
| sram_addr | output | ADDR_W | Command address |
| sram_dq_oe | output | 1 | Controller drives the shared data bus |
| sram_d_rise | output | DATA_W | Write beat for the rising half |
| sram_d_fall | output | DATA_W | Write beat for the falling half |
| sram_bw_rise_n | output | BYTES | Byte enables for the rising-half beat |
| sram_bw_fall_n | output | BYTES | Byte enables for the falling-half beat |
| sram_q_rise | input | DATA_W | Read beat captured on the rising half |
| sram_q_fall | input | DATA_W | Read beat captured on the falling half |
| resp_valid | output | 1 | One-cycle read completion pulse |
| resp_rdata | output | 4*DATA_W | Packed read burst, beat i at i*DATA_W |

## Verification
Every result has a fixed due cycle counted from the acceptance edge:
- the command appears in cycle a+1;
- write beats appear in a+2 and a+3;
- read beats are consumed in a+2 to a+4;
- the response pulse appears in a+5.

The bench logs the cycle number of each acceptance and samples every output on the falling clock edge. Each comparison is made only in the cycle that this arithmetic predicts. A behavioural memory model answers reads using the same lane timing and flags any cycle in which both sides would drive the bus.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

  typedef enum logic {
    RW_WRITE = 1'b0,
    RW_READ  = 1'b1
  } rw_e;

  localparam int unsigned BURST_LEN = 4;

  // May a new command be placed in the slot after this cycle?
  // cmd_now : a command occupies the current cycle
  // rd_prev : a read command occupied the previous cycle
  function automatic logic may_issue(logic cmd_now, logic rd_prev, logic want_wr);
    return !cmd_now && !(want_wr && rd_prev);
  endfunction

endpackage

// File: rtl/ddrb_cmd_issue.sv
module ddrb_cmd_issue
  import ddrb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              accept,
  output logic              sram_ld_n,
  output logic              sram_rw_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              wr_st1,
  output logic              wr_st2,
  output logic              rd_st1,
  output logic              rd_st2,
  output logic              rd_st3
);

  logic              cmd_q;
  rw_e               rw_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = may_issue(cmd_q, rd_st1, req_write);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      rw_q   <= RW_READ;
      addr_q <= '0;
      wr_st1 <= 1'b0;
      wr_st2 <= 1'b0;
      rd_st1 <= 1'b0;
      rd_st2 <= 1'b0;
      rd_st3 <= 1'b0;
    end else begin
      cmd_q  <= accept;
      rw_q   <= (accept && req_write) ? RW_WRITE : RW_READ;
      if (accept) addr_q <= req_addr;
      wr_st1 <= cmd_q && (rw_q == RW_WRITE);
      wr_st2 <= wr_st1;
      rd_st1 <= cmd_q && (rw_q == RW_READ);
      rd_st2 <= rd_st1;
      rd_st3 <= rd_st2;
    end
  end

  assign sram_ld_n = !cmd_q;
  assign sram_rw_n = rw_q;
  assign sram_addr = addr_q;

  // R1: command slots never adjacent
  p_cmd_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ld_n |=> sram_ld_n);

endmodule

// File: rtl/ddrb_wr_lane.sv
module ddrb_wr_lane
  import ddrb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [BURST_LEN*DATA_W-1:0]   wdata,
  input  logic [BURST_LEN*DATA_W/8-1:0] bw_n,
  input  logic                          wr_st1,
  input  logic                          wr_st2,
  output logic                          dq_oe,
  output logic [DATA_W-1:0]             d_rise,
  output logic [DATA_W-1:0]             d_fall,
  output logic [DATA_W/8-1:0]           bw_rise_n,
  output logic [DATA_W/8-1:0]           bw_fall_n
);

  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] word_q [BURST_LEN];
  logic [BYTES-1:0]  msk_q  [BURST_LEN];
  logic [DATA_W-1:0] late_d [2];
  logic [BYTES-1:0]  late_m [2];

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q[b] <= '0;
        msk_q[b]  <= '1;
      end else if (load) begin
        word_q[b] <= wdata[b*DATA_W +: DATA_W];
        msk_q[b]  <= bw_n[b*BYTES +: BYTES];
      end
    end
  end

  // Second half of the burst moves aside so a new write may load at once.
  for (genvar h = 0; h < 2; h++) begin : g_late
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        late_d[h] <= '0;
        late_m[h] <= '1;
      end else if (wr_st1) begin
        late_d[h] <= word_q[h+2];
        late_m[h] <= msk_q[h+2];
      end
    end
  end

  always_comb begin
    d_rise    = '0;
    d_fall    = '0;
    bw_rise_n = '1;
    bw_fall_n = '1;
    if (wr_st1) begin
      d_rise    = word_q[0];
      d_fall    = word_q[1];
      bw_rise_n = msk_q[0];
      bw_fall_n = msk_q[1];
    end else if (wr_st2) begin
      d_rise    = late_d[0];
      d_fall    = late_d[1];
      bw_rise_n = late_m[0];
      bw_fall_n = late_m[1];
    end
  end

  assign dq_oe = wr_st1 || wr_st2;

  // R4: the second data cycle always follows the first
  p_two_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st1 |=> (dq_oe && !wr_st1));

endmodule

// File: rtl/ddrb_rd_gather.sv
module ddrb_rd_gather
  import ddrb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_st1,
  input  logic                        rd_st2,
  input  logic                        rd_st3,
  input  logic [DATA_W-1:0]           q_rise,
  input  logic [DATA_W-1:0]           q_fall,
  output logic                        resp_valid,
  output logic [BURST_LEN*DATA_W-1:0] resp_rdata
);

  logic [DATA_W-1:0] beat0_q, beat1_q, beat2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat0_q    <= '0;
      beat1_q    <= '0;
      beat2_q    <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      if (rd_st1) beat0_q <= q_fall;
      if (rd_st2) begin
        beat1_q <= q_rise;
        beat2_q <= q_fall;
      end
      resp_valid <= rd_st3;
      if (rd_st3) resp_rdata <= {q_rise, beat2_q, beat1_q, beat0_q};
    end
  end

  // R8: completion strobe lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

endmodule

// File: rtl/ddrb_host_ctrl.sv
module ddrb_host_ctrl
  import ddrb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BURST_LEN*DATA_W-1:0]   req_wdata,
  input  logic [BURST_LEN*DATA_W/8-1:0] req_bw_n,
  output logic                          req_ready,
  output logic                          sram_ld_n,
  output logic                          sram_rw_n,
  output logic [ADDR_W-1:0]             sram_addr,
  output logic                          sram_dq_oe,
  output logic [DATA_W-1:0]             sram_d_rise,
  output logic [DATA_W-1:0]             sram_d_fall,
  output logic [DATA_W/8-1:0]           sram_bw_rise_n,
  output logic [DATA_W/8-1:0]           sram_bw_fall_n,
  input  logic [DATA_W-1:0]             sram_q_rise,
  input  logic [DATA_W-1:0]             sram_q_fall,
  output logic                          resp_valid,
  output logic [BURST_LEN*DATA_W-1:0]   resp_rdata
);

  logic accept;
  logic wr_st1, wr_st2;
  logic rd_st1, rd_st2, rd_st3;
  logic rd_window;

  ddrb_cmd_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .accept    (accept),
    .sram_ld_n (sram_ld_n),
    .sram_rw_n (sram_rw_n),
    .sram_addr (sram_addr),
    .wr_st1    (wr_st1),
    .wr_st2    (wr_st2),
    .rd_st1    (rd_st1),
    .rd_st2    (rd_st2),
    .rd_st3    (rd_st3)
  );

  ddrb_wr_lane #(.DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && req_write),
    .wdata     (req_wdata),
    .bw_n      (req_bw_n),
    .wr_st1    (wr_st1),
    .wr_st2    (wr_st2),
    .dq_oe     (sram_dq_oe),
    .d_rise    (sram_d_rise),
    .d_fall    (sram_d_fall),
    .bw_rise_n (sram_bw_rise_n),
    .bw_fall_n (sram_bw_fall_n)
  );

  ddrb_rd_gather #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_st1     (rd_st1),
    .rd_st2     (rd_st2),
    .rd_st3     (rd_st3),
    .q_rise     (sram_q_rise),
    .q_fall     (sram_q_fall),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata)
  );

  // Named event: the memory may be driving the shared bus in this cycle.
  assign rd_window = rd_st1 || rd_st2 || rd_st3;

  // R5: idle slots never signal a write
  p_idle_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ld_n |-> sram_rw_n);

  // R6: no two drivers on the shared bus
  p_no_contend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_window |-> !sram_dq_oe);

  // R4: a write command is followed by the controller driving the bus
  p_wr_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ld_n && !sram_rw_n) |=> sram_dq_oe);

  // R8: a read command leads to a completion strobe four cycles later
  p_rd_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st3 |=> resp_valid);

endmodule

// File: tb/ddrb_host_ctrl_tb_top.sv
module ddrb_host_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [4*DW-1:0]   req_wdata = '0;
  logic [4*NB-1:0]   req_bw_n = '1;
  logic              req_ready;
  logic              sram_ld_n, sram_rw_n, sram_dq_oe;
  logic [AW-1:0]     sram_addr;
  logic [DW-1:0]     sram_d_rise, sram_d_fall;
  logic [NB-1:0]     sram_bw_rise_n, sram_bw_fall_n;
  logic [DW-1:0]     sram_q_rise = '0;
  logic [DW-1:0]     sram_q_fall = '0;
  logic              resp_valid;
  logic [4*DW-1:0]   resp_rdata;

  ddrb_host_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bw_n(req_bw_n),
    .req_ready(req_ready), .sram_ld_n(sram_ld_n), .sram_rw_n(sram_rw_n),
    .sram_addr(sram_addr), .sram_dq_oe(sram_dq_oe), .sram_d_rise(sram_d_rise),
    .sram_d_fall(sram_d_fall), .sram_bw_rise_n(sram_bw_rise_n),
    .sram_bw_fall_n(sram_bw_fall_n), .sram_q_rise(sram_q_rise),
    .sram_q_fall(sram_q_fall), .resp_valid(resp_valid), .resp_rdata(resp_rdata)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  // memory model and independent scoreboard, index {addr, beat}
  logic [DW-1:0] mem [0:(1<<AW)*4-1];
  logic [DW-1:0] sb  [0:(1<<AW)*4-1];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [NB-1:0] en_n);
    logic [DW-1:0] r = old;
    for (int j = 0; j < NB; j++) if (!en_n[j]) r[j*8 +: 8] = nw[j*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(int s, int a, int b);
    return DW'((a * 773 + b * 2311 + s * 4099) ^ (a << 4));
  endfunction

  // expectation queues
  int            c_acc [0:1023];
  logic [AW-1:0] c_addr[0:1023];
  bit            c_wr  [0:1023];
  int            c_head = 0, c_tail = 0;
  int            r_acc [0:1023];
  logic [4*DW-1:0] r_exp [0:1023];
  int            r_head = 0, r_tail = 0;

  // model pipeline
  bit            r1 = 0, r2 = 0, r3 = 0, w1 = 0, w2 = 0, ld_prev = 0;
  logic [AW-1:0] ra1 = '0, ra2 = '0, ra3 = '0, wa1 = '0, wa2 = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (w1) begin
        mem[{wa1, 2'd0}] = merge(mem[{wa1, 2'd0}], sram_d_rise, sram_bw_rise_n);
        mem[{wa1, 2'd1}] = merge(mem[{wa1, 2'd1}], sram_d_fall, sram_bw_fall_n);
      end
      if (w2) begin
        mem[{wa2, 2'd2}] = merge(mem[{wa2, 2'd2}], sram_d_rise, sram_bw_rise_n);
        mem[{wa2, 2'd3}] = merge(mem[{wa2, 2'd3}], sram_d_fall, sram_bw_fall_n);
      end
      // R4: bus driven exactly in the two cycles after a write command
      chk(sram_dq_oe === (w1 | w2), "R4", "dq_oe window", 64'(sram_dq_oe), 64'(w1 | w2));
      // R6: no drive while the memory owns the bus
      if (r1 | r2 | r3) chk(sram_dq_oe === 1'b0, "R6", "dq_oe in read window", 64'(sram_dq_oe), 64'd0);
      // R5: idle slot keeps rw_n high
      if (sram_ld_n) chk(sram_rw_n === 1'b1, "R5", "rw_n idle", 64'(sram_rw_n), 64'd1);
      if (!sram_ld_n) begin
        chk(!ld_prev, "R1", "adjacent commands", 64'(ld_prev), 64'd0);
        if (c_head == c_tail) chk(1'b0, "R2", "unexpected command", 64'(sram_addr), 64'd0);
        else begin
          chk(cyc == c_acc[c_head] + 1, "R2", "command cycle", 64'(cyc), 64'(c_acc[c_head] + 1));
          chk(sram_addr === c_addr[c_head], "R2", "command addr", 64'(sram_addr), 64'(c_addr[c_head]));
          chk(sram_rw_n === !c_wr[c_head], "R2", "command rw_n", 64'(sram_rw_n), 64'(!c_wr[c_head]));
          c_head++;
        end
      end
      // drive read beats for this cycle
      sram_q_rise = '0;
      sram_q_fall = '0;
      if (r1) sram_q_fall = mem[{ra1, 2'd0}];
      if (r2) begin
        sram_q_rise = mem[{ra2, 2'd1}];
        sram_q_fall = mem[{ra2, 2'd2}];
      end
      if (r3) sram_q_rise = mem[{ra3, 2'd3}];
      // R7/R8: response content and timing
      if (resp_valid) begin
        if (r_head == r_tail) chk(1'b0, "R8", "unexpected resp_valid", 64'd1, 64'd0);
        else begin
          chk(cyc == r_acc[r_head] + 5, "R8", "resp cycle", 64'(cyc), 64'(r_acc[r_head] + 5));
          chk(resp_rdata === r_exp[r_head], "R7", "resp data", resp_rdata, r_exp[r_head]);
          r_head++;
        end
      end
      r3 = r2; ra3 = ra2; r2 = r1; ra2 = ra1;
      w2 = w1; wa2 = wa1;
      r1 = !sram_ld_n && sram_rw_n;
      w1 = !sram_ld_n && !sram_rw_n;
      ra1 = sram_addr; wa1 = sram_addr;
      ld_prev = !sram_ld_n;
    end
  end

  int prev_acc = 0;
  bit prev_wr = 0;
  bit have_prev = 0;

  task automatic send(input bit wr, input int a, input int seed, input logic [4*NB-1:0] m,
                      input bit chain);
    logic [4*DW-1:0] wd;
    logic [4*DW-1:0] ex;
    int acc;
    for (int b = 0; b < 4; b++) wd[b*DW +: DW] = pat(seed, a, b);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = wd;
    req_bw_n  = m;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    if (chain && have_prev) begin
      // R3: spacing under continuous requests
      chk((acc - prev_acc) == ((prev_wr == 0 && wr) ? 3 : 2), "R3", "accept spacing",
          64'(acc - prev_acc), 64'((prev_wr == 0 && wr) ? 3 : 2));
    end
    c_acc[c_tail] = acc; c_addr[c_tail] = AW'(a); c_wr[c_tail] = wr; c_tail++;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        sb[a*4 + b] = merge(sb[a*4 + b], wd[b*DW +: DW], m[b*NB +: NB]);
    end else begin
      for (int b = 0; b < 4; b++) ex[b*DW +: DW] = sb[a*4 + b];
      r_acc[r_tail] = acc; r_exp[r_tail] = ex; r_tail++;
    end
    prev_acc = acc; prev_wr = wr; have_prev = 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    have_prev = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW) * 4; i++) begin
      mem[i] = '0;
      sb[i]  = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(sram_ld_n === 1'b1, "R9", "ld_n after reset", 64'(sram_ld_n), 64'd1);
    chk(sram_rw_n === 1'b1, "R9", "rw_n after reset", 64'(sram_rw_n), 64'd1);
    chk(sram_dq_oe === 1'b0, "R9", "dq_oe after reset", 64'(sram_dq_oe), 64'd0);
    chk(resp_valid === 1'b0, "R9", "resp_valid after reset", 64'(resp_valid), 64'd0);
    #1;
    chk(req_ready === 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
    @(negedge clk);

    // fill every burst with all bytes enabled (R4)
    for (int a = 0; a < (1 << AW); a++) send(1'b1, a, 1, '0, 1'b1);
    idle(4);
    // masked rewrite, sweeping all byte-enable combinations (R4)
    for (int a = 0; a < (1 << AW); a++) send(1'b1, a, 2, 8'(a), 1'b1);
    idle(4);
    // read everything back back-to-back (R7, R8, R3)
    for (int a = 0; a < (1 << AW); a++) send(1'b0, a, 0, '1, 1'b1);
    idle(8);
    // alternating write/read turnarounds on the same burst (R3, R6, R7)
    for (int a = 0; a < 32; a++) begin
      send(1'b1, a * 5 % (1 << AW), 3 + a, 8'(a * 37), 1'b1);
      send(1'b0, a * 5 % (1 << AW), 0, '1, 1'b1);
    end
    idle(4);
    // read followed by write with gaps, then read-after-read pairs (R3)
    for (int a = 0; a < 16; a++) begin
      send(1'b0, a, 0, '1, 1'b1);
      send(1'b0, a + 100, 0, '1, 1'b1);
      send(1'b1, a + 200, 9, 8'hA5, 1'b1);
    end
    idle(10);
    // R8: every read answered, nothing outstanding
    chk(r_head == r_tail, "R8", "responses outstanding", 64'(r_tail - r_head), 64'd0);
    chk(c_head == c_tail, "R2", "commands outstanding", 64'(c_tail - c_head), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule